// File: doc/BRIEF.md
# Wake-Up Clock Source Sequencer

This block controls how a small system enters and leaves its low-power modes. Software presents a mode entry request together with the target mode. The block records that mode and prepares the system for it. For the deeper modes it first raises a power-down request to an attached converter. It then switches the main PLL off. When any wake source fires, the block decides from the recorded mode whether and when to enable the PLL, and how to drive the system clock mux select. The select picks either the PLL reference clock or the PLL output. A programmable lock-time count, in reference-clock cycles, sets the moment of the switch.

A wake from IDLE returns at once with the PLL untouched. A wake from DEEP-IDLE re-enables the PLL and keeps the mux on the PLL output. A wake from STOP or DEEP-STOP runs on the reference clock until the lock time expires and then moves to the PLL output. A wake from SLEEP leaves everything in its reset state. After reset, and after a SLEEP wake, software starts the PLL with a boot pulse.

The entry request is a valid/ready pair. `enter_ready` is high only while the block is in its running state. A request is taken on a clock edge where both signals are high. While `enter_ready` is low, the request is held off, and the inputs must stay stable until acceptance. All other pins are plain level control and status.

Top module: `wake_clk_seq`

## Requirements
- R1: After reset, pll_en=0, clk_sel=0 (0 selects the reference clock, 1 selects the PLL output), lock_done=0, last_mode=0 and enter_ready=1.
- R2: A pll_boot pulse in the running state, while the PLL is off and no entry request is presented, raises pll_en on the next edge. clk_sel and lock_done rise together exactly N+1 cycles after pll_en rises, where N is lock_cycles (N=0 gives one cycle).
- R3: Entry requests use the mode codes 1=IDLE, 2=DEEP-IDLE, 3=STOP, 4=DEEP-STOP, 5=SLEEP. enter_ready is high only in the running state. An accepted request with any other code leaves the block running with its outputs unchanged.
- R4: Entry to DEEP-IDLE with enter_top_on=0, STOP, DEEP-STOP or SLEEP raises conv_pd for one cycle with the PLL still on. pll_en falls on the following edge. conv_pd stays high until the block is running again.
- R5: In the running state, in IDLE, and in DEEP-IDLE with enter_top_on=1, conv_pd equals the inverse of conv_run_sw.
- R6: IDLE entry keeps pll_en and clk_sel. A wake from IDLE returns to running on the next edge, with both unchanged.
- R7: DEEP-IDLE entry turns pll_en off while clk_sel stays at 1. A wake turns pll_en on, and clk_sel remains 1 through and after the lock count.
- R8: STOP and DEEP-STOP entry set clk_sel to 0. A wake turns pll_en on. clk_sel stays 0 until the lock count of R2 ends, then becomes 1.
- R9: A wake from SLEEP returns to running with pll_en=0, clk_sel=0 and lock_done=0, the reset values.
- R10: Wake inputs are ignored while the block is running. pll_en, clk_sel, lock_done and enter_ready do not change.
- R11: The external-interrupt, alarm and miscellaneous wake inputs act identically.
- R12: On every wake, last_mode takes the code of the mode that was exited. clk_sel changes at most once per wake sequence, and only by rising at the same edge as lock_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter_valid | input | 1 | Low-power entry request |
| enter_ready | output | 1 | Entry request can be accepted (running state) |
| enter_mode | input | 3 | Target mode code |
| enter_top_on | input | 1 | DEEP-IDLE keeps top domain powered |
| conv_run_sw | input | 1 | Software run bit for the converter |
| pll_boot | input | 1 | Start PLL and lock count from running state |
| wake_ext_irq | input | 1 | External interrupt wake |
| wake_alarm | input | 1 | Alarm wake |
| wake_misc | input | 1 | Other wake source |
| lock_cycles | input | 16 | PLL lock time in reference cycles |
| pll_en | output | 1 | PLL enable |
| clk_sel | output | 1 | System clock mux select, 1 = PLL output |
| conv_pd | output | 1 | Converter power-down request |
| lock_done | output | 1 | Lock count complete with PLL running |
| last_mode | output | 3 | Code of the mode last exited |

## Verification
A wrong recorded mode shows at the first wake edge as a wrong pll_en, or as a wrong last_mode code. An off-by-one or a stuck lock counter shifts the rise of clk_sel and lock_done away from cycle N+1, and the bench samples that exact cycle. A missing preparation cycle removes the single cycle in which conv_pd is high while pll_en is still on. A leaking wake path alters pll_en or enter_ready one edge after a wake pulse in the running state.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    LP_NONE  = 3'd0,
    LP_IDLE  = 3'd1,
    LP_DIDLE = 3'd2,
    LP_STOP  = 3'd3,
    LP_DSTOP = 3'd4,
    LP_SLEEP = 3'd5
  } lp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_PREP,
    ST_LP,
    ST_LOCK
  } seq_state_e;

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    return (m >= 3'd1) && (m <= 3'd5);
  endfunction

  // Modes whose entry must power the converter down first.
  function automatic logic mode_needs_pd(input logic [MODE_W-1:0] m, input logic top_on);
    return (m == LP_DIDLE && !top_on) || (m == LP_STOP) || (m == LP_DSTOP) || (m == LP_SLEEP);
  endfunction

  // Modes that leave the system on the reference clock around wake-up.
  function automatic logic mode_forces_ref(input logic [MODE_W-1:0] m);
    return (m == LP_STOP) || (m == LP_DSTOP) || (m == LP_SLEEP);
  endfunction
endpackage

// File: rtl/wcs_wake_merge.sv
module wcs_wake_merge #(
  parameter int unsigned N_SRC = 3
) (
  input  logic [N_SRC-1:0] src,
  output logic             any_wake
);
  logic [N_SRC:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < N_SRC; i++) begin : g_or
    assign chain[i+1] = chain[i] | src[i];
  end
  assign any_wake = chain[N_SRC];
endmodule

// File: rtl/wcs_lock_timer.sv
module wcs_lock_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= limit;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run_q && (cnt_q == '0);

  // R2: counting proceeds one step per cycle and stops after expiry
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0 && !load) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));
  a_r2_stop_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> !run_q);
endmodule

// File: rtl/wcs_conv_gate.sv
module wcs_conv_gate (
  input  logic run_state,
  input  logic deep_mode,
  input  logic conv_run_sw,
  output logic conv_pd
);
  // Forced power-down for the whole deep sequence, software bit otherwise.
  assign conv_pd = (!run_state && deep_mode) || !conv_run_sw;
endmodule

// File: rtl/wcs_mode_fsm.sv
module wcs_mode_fsm
  import wcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_valid,
  input  logic [MODE_W-1:0] enter_mode,
  input  logic              enter_top_on,
  input  logic              pll_boot,
  input  logic              wake,
  input  logic              lock_expired,
  output logic              enter_ready,
  output logic              timer_load,
  output logic              run_state,
  output logic              deep_mode,
  output logic              pll_en,
  output logic              clk_sel,
  output logic              lock_done,
  output logic [MODE_W-1:0] last_mode
);
  seq_state_e        state_q;
  lp_mode_e          mode_q;
  logic              deep_q, pll_q, sel_q, done_q;
  logic [MODE_W-1:0] last_q;
  logic              enter_fire, boot_fire, wake_lock;

  assign enter_ready = (state_q == ST_RUN);
  assign enter_fire  = enter_valid && enter_ready;
  assign boot_fire   = (state_q == ST_RUN) && !enter_valid && pll_boot && !pll_q;
  assign wake_lock   = (state_q == ST_LP) && wake && (mode_q != LP_IDLE) && (mode_q != LP_SLEEP);
  assign timer_load  = boot_fire || wake_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      mode_q  <= LP_NONE;
      deep_q  <= 1'b0;
      pll_q   <= 1'b0;
      sel_q   <= 1'b0;
      done_q  <= 1'b0;
      last_q  <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (enter_fire) begin
            if (mode_known(enter_mode)) begin
              mode_q <= lp_mode_e'(enter_mode);
              deep_q <= mode_needs_pd(enter_mode, enter_top_on);
              if (mode_needs_pd(enter_mode, enter_top_on)) begin
                state_q <= ST_PREP;
                if (mode_forces_ref(enter_mode)) sel_q <= 1'b0;
              end else begin
                state_q <= ST_LP;
                if (enter_mode != LP_IDLE) begin
                  pll_q  <= 1'b0;
                  done_q <= 1'b0;
                end
              end
            end
          end else if (boot_fire) begin
            state_q <= ST_LOCK;
            pll_q   <= 1'b1;
            sel_q   <= 1'b0;
            mode_q  <= LP_NONE;
            deep_q  <= 1'b0;
          end
        end
        ST_PREP: begin
          state_q <= ST_LP;
          pll_q   <= 1'b0;
          done_q  <= 1'b0;
        end
        ST_LP: begin
          if (wake) begin
            last_q <= mode_q;
            if (mode_q == LP_IDLE) begin
              state_q <= ST_RUN;
              mode_q  <= LP_NONE;
              deep_q  <= 1'b0;
            end else if (mode_q == LP_SLEEP) begin
              state_q <= ST_RUN;
              mode_q  <= LP_NONE;
              deep_q  <= 1'b0;
              pll_q   <= 1'b0;
              sel_q   <= 1'b0;
              done_q  <= 1'b0;
            end else begin
              state_q <= ST_LOCK;
              pll_q   <= 1'b1;
            end
          end
        end
        ST_LOCK: begin
          if (lock_expired) begin
            state_q <= ST_RUN;
            sel_q   <= 1'b1;
            done_q  <= 1'b1;
            mode_q  <= LP_NONE;
            deep_q  <= 1'b0;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign run_state = (state_q == ST_RUN);
  assign deep_mode = deep_q;
  assign pll_en    = pll_q;
  assign clk_sel   = sel_q;
  assign lock_done = done_q;
  assign last_mode = last_q;

  // R12: the mux select only rises together with lock completion
  a_r12_sel_rise_with_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> $rose(done_q));
  // R12: no fall of the select once a wake sequence is under way
  a_r12_no_sel_fall_in_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LP || state_q == ST_LOCK) |=> !$fell(sel_q));
  // R2: lock status implies a running PLL
  a_r2_done_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> pll_q);
  // R10: wake pulses in the running state change nothing
  a_r10_run_wake_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !enter_valid && !pll_boot) |=>
      ($stable(pll_q) && $stable(sel_q) && state_q == ST_RUN));
  // R6: IDLE keeps the PLL untouched
  a_r6_idle_keeps_pll: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LP && mode_q == LP_IDLE) |=> $stable(pll_q));
endmodule

// File: rtl/wake_clk_seq.sv
module wake_clk_seq
  import wcs_pkg::*;
#(
  parameter int unsigned LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter_valid,
  output logic              enter_ready,
  input  logic [2:0]        enter_mode,
  input  logic              enter_top_on,
  input  logic              conv_run_sw,
  input  logic              pll_boot,
  input  logic              wake_ext_irq,
  input  logic              wake_alarm,
  input  logic              wake_misc,
  input  logic [LOCK_W-1:0] lock_cycles,
  output logic              pll_en,
  output logic              clk_sel,
  output logic              conv_pd,
  output logic              lock_done,
  output logic [2:0]        last_mode
);
  localparam int unsigned N_WAKE = 3;

  logic any_wake, lock_expired, timer_load, run_state, deep_mode;

  wcs_wake_merge #(.N_SRC(N_WAKE)) u_wake (
    .src      ({wake_misc, wake_alarm, wake_ext_irq}),
    .any_wake (any_wake)
  );

  wcs_lock_timer #(.CNT_W(LOCK_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .limit   (lock_cycles),
    .expired (lock_expired)
  );

  wcs_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_valid  (enter_valid),
    .enter_mode   (enter_mode),
    .enter_top_on (enter_top_on),
    .pll_boot     (pll_boot),
    .wake         (any_wake),
    .lock_expired (lock_expired),
    .enter_ready  (enter_ready),
    .timer_load   (timer_load),
    .run_state    (run_state),
    .deep_mode    (deep_mode),
    .pll_en       (pll_en),
    .clk_sel      (clk_sel),
    .lock_done    (lock_done),
    .last_mode    (last_mode)
  );

  wcs_conv_gate u_conv (
    .run_state   (run_state),
    .deep_mode   (deep_mode),
    .conv_run_sw (conv_run_sw),
    .conv_pd     (conv_pd)
  );

  // R4: a deep-mode PLL shutdown is preceded by a converter power-down cycle
  a_r4_pd_before_pll_off: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_mode && $fell(pll_en)) |-> $past(conv_pd));
  // R5: outside deep sequences the converter follows the software bit
  a_r5_pd_follows_sw: assert property (@(posedge clk) disable iff (!rst_n)
    (!deep_mode) |-> (conv_pd == !conv_run_sw));
endmodule

// File: tb/test_wake_clk_seq.sv
module test_wake_clk_seq;
  localparam int CLK_PERIOD = 10;
  localparam int N_LOCK = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enter_valid = 1'b0;
  logic [2:0] enter_mode = '0;
  logic enter_top_on = 1'b0;
  logic conv_run_sw = 1'b1;
  logic pll_boot = 1'b0;
  logic wake_ext_irq = 1'b0, wake_alarm = 1'b0, wake_misc = 1'b0;
  logic [15:0] lock_cycles = 16'(N_LOCK);
  logic enter_ready, pll_en, clk_sel, conv_pd, lock_done;
  logic [2:0] last_mode;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_clk_seq i_wake_clk_seq (
    .clk(clk), .rst_n(rst_n), .enter_valid(enter_valid), .enter_ready(enter_ready),
    .enter_mode(enter_mode), .enter_top_on(enter_top_on), .conv_run_sw(conv_run_sw),
    .pll_boot(pll_boot), .wake_ext_irq(wake_ext_irq), .wake_alarm(wake_alarm),
    .wake_misc(wake_misc), .lock_cycles(lock_cycles), .pll_en(pll_en), .clk_sel(clk_sel),
    .conv_pd(conv_pd), .lock_done(lock_done), .last_mode(last_mode)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic do_enter(input logic [2:0] m, input logic top_on);
    enter_valid = 1'b1; enter_mode = m; enter_top_on = top_on;
    step();
    enter_valid = 1'b0;
  endtask

  task automatic do_wake(input int src);
    case (src)
      0: wake_ext_irq = 1'b1;
      1: wake_alarm = 1'b1;
      default: wake_misc = 1'b1;
    endcase
    step();
    wake_ext_irq = 1'b0; wake_alarm = 1'b0; wake_misc = 1'b0;
  endtask

  // Called one cycle after pll_en rose; checks the N+1 cycle lock window.
  task automatic wait_lock(input int n, input int sel_before, input string tag);
    for (int k = 0; k < n; k++) begin
      chk_eq({tag, " sel before lock"}, clk_sel, sel_before);
      chk_eq({tag, " lock_done early"}, lock_done, 0);
      step();
    end
    chk_eq({tag, " sel before lock"}, clk_sel, sel_before);
    step();
    chk_eq({tag, " sel after lock"}, clk_sel, 1);
    chk_eq({tag, " lock_done"}, lock_done, 1);
    chk_eq({tag, " ready after lock"}, enter_ready, 1);
  endtask

  task automatic t_reset();
    chk_eq("R1 pll_en", pll_en, 0);
    chk_eq("R1 clk_sel", clk_sel, 0);
    chk_eq("R1 lock_done", lock_done, 0);
    chk_eq("R1 last_mode", last_mode, 0);
    chk_eq("R1 enter_ready", enter_ready, 1);
    chk_eq("R5 conv_pd run", conv_pd, 0);
  endtask

  task automatic t_boot(input int n);
    lock_cycles = 16'(n);
    pll_boot = 1'b1;
    step();
    pll_boot = 1'b0;
    chk_eq("R2 pll_en on boot", pll_en, 1);
    chk_eq("R2 ready low in lock", enter_ready, 0);
    wait_lock(n, 0, "R2");
  endtask

  task automatic t_sw_bit();
    conv_run_sw = 1'b0; #1;
    chk_eq("R5 conv_pd sw=0", conv_pd, 1);
    conv_run_sw = 1'b1; #1;
    chk_eq("R5 conv_pd sw=1", conv_pd, 0);
  endtask

  task automatic t_idle();
    do_enter(3'd1, 1'b0);
    chk_eq("R6 pll kept", pll_en, 1);
    chk_eq("R6 sel kept", clk_sel, 1);
    chk_eq("R3 ready low in lp", enter_ready, 0);
    chk_eq("R5 conv_pd idle", conv_pd, 0);
    conv_run_sw = 1'b0; #1;
    chk_eq("R5 conv_pd idle sw=0", conv_pd, 1);
    conv_run_sw = 1'b1;
    step();
    do_wake(0);
    chk_eq("R6 back to run", enter_ready, 1);
    chk_eq("R6 pll after wake", pll_en, 1);
    chk_eq("R6 sel after wake", clk_sel, 1);
    chk_eq("R12 last_mode idle", last_mode, 1);
  endtask

  task automatic t_didle_on();
    do_enter(3'd2, 1'b1);
    chk_eq("R7 pll off", pll_en, 0);
    chk_eq("R7 sel stays", clk_sel, 1);
    chk_eq("R5 conv_pd didle top on", conv_pd, 0);
    do_wake(1);
    chk_eq("R7 pll on after wake", pll_en, 1);
    chk_eq("R11 alarm wake", lock_done, 0);
    wait_lock(N_LOCK, 1, "R7");
    chk_eq("R12 last_mode didle", last_mode, 2);
  endtask

  task automatic t_didle_off();
    do_enter(3'd2, 1'b0);
    chk_eq("R4 conv_pd prep", conv_pd, 1);
    chk_eq("R4 pll still on in prep", pll_en, 1);
    step();
    chk_eq("R4 pll off after prep", pll_en, 0);
    chk_eq("R4 conv_pd held", conv_pd, 1);
    do_wake(2);
    chk_eq("R11 misc wake", pll_en, 1);
    chk_eq("R4 conv_pd held in lock", conv_pd, 1);
    wait_lock(N_LOCK, 1, "R7");
    chk_eq("R4 conv_pd released", conv_pd, 0);
  endtask

  task automatic t_stop(input logic [2:0] m, input int src, input int n, input string tag);
    lock_cycles = 16'(n);
    do_enter(m, 1'b0);
    chk_eq({tag, " R4 conv_pd prep"}, conv_pd, 1);
    chk_eq({tag, " R8 sel to ref"}, clk_sel, 0);
    chk_eq({tag, " R4 pll on in prep"}, pll_en, 1);
    step();
    chk_eq({tag, " R4 pll off"}, pll_en, 0);
    step(); step();
    chk_eq({tag, " R8 stays asleep"}, enter_ready, 0);
    do_wake(src);
    chk_eq({tag, " R8 pll on after wake"}, pll_en, 1);
    wait_lock(n, 0, {tag, " R8"});
    chk_eq({tag, " R12 last_mode"}, last_mode, int'(m));
    chk_eq({tag, " R4 conv_pd released"}, conv_pd, 0);
  endtask

  task automatic t_sleep();
    do_enter(3'd5, 1'b0);
    chk_eq("R4 conv_pd sleep prep", conv_pd, 1);
    step();
    chk_eq("R9 pll off in sleep", pll_en, 0);
    do_wake(0);
    chk_eq("R9 pll stays off", pll_en, 0);
    chk_eq("R9 sel ref", clk_sel, 0);
    chk_eq("R9 lock_done cleared", lock_done, 0);
    chk_eq("R9 running", enter_ready, 1);
    chk_eq("R12 last_mode sleep", last_mode, 5);
    step(); step();
    chk_eq("R9 pll still off", pll_en, 0);
  endtask

  task automatic t_run_wake();
    wake_ext_irq = 1'b1; wake_alarm = 1'b1; wake_misc = 1'b1;
    step();
    wake_ext_irq = 1'b0; wake_alarm = 1'b0; wake_misc = 1'b0;
    step();
    chk_eq("R10 pll unchanged", pll_en, 1);
    chk_eq("R10 sel unchanged", clk_sel, 1);
    chk_eq("R10 lock_done unchanged", lock_done, 1);
    chk_eq("R10 still running", enter_ready, 1);
  endtask

  task automatic t_bad_mode();
    do_enter(3'd6, 1'b0);
    chk_eq("R3 bad code ready", enter_ready, 1);
    chk_eq("R3 bad code pll", pll_en, 1);
    do_enter(3'd0, 1'b0);
    chk_eq("R3 zero code ready", enter_ready, 1);
    chk_eq("R3 zero code sel", clk_sel, 1);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_sw_bit();
    t_boot(N_LOCK);
    t_run_wake();
    t_bad_mode();
    t_idle();
    t_didle_on();
    t_didle_off();
    t_stop(3'd3, 0, N_LOCK, "STOP");
    t_stop(3'd4, 1, N_LOCK, "DSTOP");
    t_stop(3'd3, 2, 0, "STOP N0");
    lock_cycles = 16'(N_LOCK);
    t_sleep();
    t_boot(0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule